// File: doc/BRIEF.md
# Early-Resolution Operand Source Selector

This combinational unit serves a pipeline that resolves conditional branches and register-indirect jumps (JALR) in the decode stage. Those instructions need their source registers before the normal execute-stage bypass can supply them. For each of the two source operands of the decoding instruction, the unit reports where the freshest value lives. The candidates are the instruction one stage ahead (ID/EX), the one two stages ahead (EX/MEM), the one three stages ahead (MEM/WB), or the register file.

The answer is a 4-bit source code for each operand, and the decode-stage operand muxes consume it. The encoding tells conditional-branch consumers apart from JALR consumers. For JALR, it also tells a load producer apart from a non-load producer in the EX/MEM and MEM/WB stages. The operand muxes, the comparator and the stall decision sit outside this block. A load that is still in ID/EX is a stall case, and the stall logic handles it.

Top module: `early_operand_src`

## Requirements
- R1: When no stage holds a matching nonzero destination, the operand's code is 4'b0000 (read the register file).
- R2: With `is_cond_branch`=1, the code is 4'b0001 for an ID/EX match, 4'b0010 for an EX/MEM match and 4'b0011 for a MEM/WB match. The load flags have no effect on these codes.
- R3: With `is_cond_branch`=0, an ID/EX match gives 4'b0110.
- R4: With `is_cond_branch`=0, an EX/MEM match gives 4'b0111 when `mem_is_load`=0 and 4'b1001 when `mem_is_load`=1.
- R5: With `is_cond_branch`=0, a MEM/WB match gives 4'b1000 when `wb_is_load`=0 and 4'b1010 when `wb_is_load`=1.
- R6: When several stages match, the youngest stage decides the code: ID/EX first, then EX/MEM, then MEM/WB.
- R7: A destination index of 0 never matches. An operand whose index is 0 therefore always gets 4'b0000.
- R8: The two operand codes are computed independently by the same rule, so equal indices give equal codes.
- R9: `is_cond_branch`=0 selects the JALR code set {0000, 0110, 0111, 1000, 1001, 1010}. `is_cond_branch`=1 selects the set {0000, 0001, 0010, 0011}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| exe_dst | input | REG_AW | Destination index held in ID/EX |
| mem_dst | input | REG_AW | Destination index held in EX/MEM |
| wb_dst | input | REG_AW | Destination index held in MEM/WB |
| mem_is_load | input | 1 | The EX/MEM instruction is a load |
| wb_is_load | input | 1 | The MEM/WB instruction is a load |
| src_a_idx | input | REG_AW | First source index (rs1) of the decoding instruction |
| src_b_idx | input | REG_AW | Second source index (rs2) of the decoding instruction |
| is_cond_branch | input | 1 | 1 = conditional branch, 0 = JALR |
| src_a_code | output | 4 | Source code for the first operand |
| src_b_code | output | 4 | Source code for the second operand |

## Verification
The bench builds the block with REG_AW=2. That gives four register indices, including index 0. Every combination of the three destinations, the two load flags, both source indices and the consumer kind is applied, 8192 vectors in all. This reaches every single, double and triple overlap, every case with x0 as producer or consumer, and every load/non-load variant. Each code is compared against a priority model written independently in the bench.

// File: rtl/early_operand_src.sv
module early_operand_src #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] exe_dst,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic [REG_AW-1:0] wb_dst,
  input  logic              mem_is_load,
  input  logic              wb_is_load,
  input  logic [REG_AW-1:0] src_a_idx,
  input  logic [REG_AW-1:0] src_b_idx,
  input  logic              is_cond_branch,
  output logic [3:0]        src_a_code,
  output logic [3:0]        src_b_code
);
  localparam logic [REG_AW-1:0] ZERO_IDX = '0;

  logic exe_live, mem_live, wb_live;
  assign exe_live = exe_dst != ZERO_IDX;
  assign mem_live = mem_dst != ZERO_IDX;
  assign wb_live  = wb_dst  != ZERO_IDX;

  logic [3:0] exe_tag, mem_tag, wb_tag;
  assign exe_tag = is_cond_branch ? 4'b0001 : 4'b0110;
  assign mem_tag = is_cond_branch ? 4'b0010 : (mem_is_load ? 4'b1001 : 4'b0111);
  assign wb_tag  = is_cond_branch ? 4'b0011 : (wb_is_load  ? 4'b1010 : 4'b1000);

  logic [REG_AW-1:0] idx   [2];
  logic [3:0]        code  [2];
  assign idx[0] = src_a_idx;
  assign idx[1] = src_b_idx;

  for (genvar g = 0; g < 2; g++) begin : g_opnd
    logic hit_exe, hit_mem, hit_wb;
    assign hit_exe = exe_live && (exe_dst == idx[g]);
    assign hit_mem = mem_live && (mem_dst == idx[g]);
    assign hit_wb  = wb_live  && (wb_dst  == idx[g]);
    assign code[g] = hit_exe ? exe_tag :
                     hit_mem ? mem_tag :
                     hit_wb  ? wb_tag  : 4'b0000;
  end

  assign src_a_code = code[0];
  assign src_b_code = code[1];
endmodule

module early_operand_src_chk #(
  parameter int REG_AW = 5
) (
  input logic [REG_AW-1:0] exe_dst,
  input logic [REG_AW-1:0] src_a_idx,
  input logic [REG_AW-1:0] src_b_idx,
  input logic              is_cond_branch,
  input logic [3:0]        src_a_code,
  input logic [3:0]        src_b_code
);
  always_comb begin
    if (!$isunknown({exe_dst, src_a_idx, src_b_idx, is_cond_branch, src_a_code, src_b_code})) begin
      // R2
      branch_set_chk: assert (!is_cond_branch || src_a_code <= 4'd3);
      // R9
      jalr_set_chk: assert (is_cond_branch || src_a_code == 4'd0 ||
                            (src_a_code >= 4'd6 && src_a_code <= 4'd10));
      // R7
      zero_src_chk: assert (src_a_idx != '0 || src_a_code == 4'd0);
      // R8
      same_idx_chk: assert (src_a_idx != src_b_idx || src_a_code == src_b_code);
      // R6
      exe_first_chk: assert (src_b_idx == '0 || exe_dst != src_b_idx ||
                             src_b_code == (is_cond_branch ? 4'd1 : 4'd6));
    end
  end
endmodule

bind early_operand_src early_operand_src_chk #(.REG_AW(REG_AW)) i_chk (
  .exe_dst(exe_dst), .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
  .is_cond_branch(is_cond_branch), .src_a_code(src_a_code), .src_b_code(src_b_code)
);

// File: tb/test_early_operand_src.sv
module test_early_operand_src;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 2;
  localparam int LIMIT = 20000;

  logic clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [AW-1:0] exe_dst, mem_dst, wb_dst, a_idx, b_idx;
  logic mem_ld, wb_ld, br;
  logic [3:0] a_code, b_code;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  early_operand_src #(.REG_AW(AW)) i_early_operand_src (
    .exe_dst(exe_dst), .mem_dst(mem_dst), .wb_dst(wb_dst),
    .mem_is_load(mem_ld), .wb_is_load(wb_ld),
    .src_a_idx(a_idx), .src_b_idx(b_idx), .is_cond_branch(br),
    .src_a_code(a_code), .src_b_code(b_code)
  );

  function automatic logic [3:0] model(input logic [AW-1:0] s, output string tag);
    if (s != 0 && exe_dst == s) begin
      tag = br ? "R2/R6" : "R3/R6/R9";
      return br ? 4'd1 : 4'd6;
    end
    if (s != 0 && mem_dst == s) begin
      tag = br ? "R2/R6" : "R4/R6/R9";
      return br ? 4'd2 : (mem_ld ? 4'd9 : 4'd7);
    end
    if (s != 0 && wb_dst == s) begin
      tag = br ? "R2" : "R5/R9";
      return br ? 4'd3 : (wb_ld ? 4'd10 : 4'd8);
    end
    tag = (s == 0) ? "R7" : "R1";
    return 4'd0;
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b (exe=%0d mem=%0d wb=%0d ld=%b%b br=%b a=%0d b=%0d)",
               tag, act, exp, exe_dst, mem_dst, wb_dst, mem_ld, wb_ld, br, a_idx, b_idx);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > LIMIT && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    string ta, tb_;
    logic [3:0] ea, eb;
    // reset-like state: all zero -> register file (R1, R7)
    {exe_dst, mem_dst, wb_dst, a_idx, b_idx, mem_ld, wb_ld, br} = '0;
    #1;
    check("R1 idle", a_code, 4'd0);
    check("R1 idle", b_code, 4'd0);
    for (int v = 0; v < (1 << (5*AW + 3)); v++) begin
      {exe_dst, mem_dst, wb_dst, a_idx, b_idx, mem_ld, wb_ld, br} = v[5*AW+2:0];
      #1;
      ea = model(a_idx, ta);
      eb = model(b_idx, tb_);
      check({ta, " rs1"}, a_code, ea);
      check({tb_, " rs2"}, b_code, eb);
      if (a_idx == b_idx) check("R8 same index", a_code, b_code);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule